// File: doc/BRIEF.md
# Banked Vector Memory with Local Address Generator

This block is a data memory split into several interleaved single-port banks, paired with its own address generator. A controller configures one transfer with a single strobe: the start address, step, circular window size, beat count, FFT length, direction and addressing mode. The generator then walks the whole transfer without further input. Each beat moves one element per bank, so a vector of `NB` elements is read or written every cycle.

Four addressing modes are provided. Linear mode steps a pointer by a programmable stride and may start at any alignment. The lane crossbar rotates elements so that lane k always carries element k. Modulo mode walks a circular window whose size is any multiple of the bank count. The two FFT modes use a different bank placement, in which the bank index is the XOR of all bank-sized address digits. One of these modes streams data in natural order. The other reads or writes in bit-reversed order. With this placement, the elements of every beat, and the two operands of every radix-2 butterfly, always fall in different banks.

Top module: `vec_bank_agu`

## Requirements
- R1: After reset `busy` and `rd_valid` are low.
- R2: A `cfg_go` pulse while idle with `cfg_beats` nonzero loads all configuration inputs. `busy` then stays high for exactly `cfg_beats` cycles, with one beat issued per cycle. A pulse with `cfg_beats` equal to zero starts nothing.
- R3: A `cfg_go` pulse while `busy` is high is ignored. The running transfer keeps its addresses, direction and length, and writes nothing from the ignored request.
- R4: Mode 0 (linear): lane k of beat j accesses address `base + j*stride + k` modulo 2^AW, for any start alignment.
- R5: Mode 1 (modulo): lane k of beat j accesses `base + ((j*stride + k) mod size)`. `size` is a multiple of NB and `stride < size`.
- R6: Mode 2 (FFT natural): lane k of beat j accesses `base + j*NB + k`, with `base` NB-aligned.
- R7: Mode 3 (FFT bit-reversed): lane k of beat j accesses `base + rev_L(j*NB + k)`. rev_L reverses the low L = `cfg_log2` bits, `base` is a multiple of 2^L, and LB ≤ L ≤ AW. Data written in mode 2 and read in mode 3 comes back in bit-reversed index order.
- R8: In every mode, each beat enables every bank exactly once, so no two lanes of a beat share a bank.
- R9: Write data of beat j is taken from `wr_data` during the cycle that beat is issued. Read data of beat j appears on `rd_data`, with `rd_valid` high, in the following cycle. Lane k occupies bits `[k*DW +: DW]`.
- R10: Placement of address a is row `a >> LB`. In modes 0 and 1 the bank is `a mod NB`. In modes 2 and 3 the bank is the XOR of all LB-bit digits of a.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_go | input | 1 | Load configuration and start a transfer |
| cfg_wr | input | 1 | 1 = write transfer, 0 = read transfer |
| cfg_mode | input | 2 | 0 linear, 1 modulo, 2 FFT natural, 3 FFT bit-reversed |
| cfg_base | input | AW | Start address |
| cfg_stride | input | AW | Per-beat step (linear and modulo) |
| cfg_size | input | AW | Circular window size (modulo) |
| cfg_beats | input | AW | Number of beats |
| cfg_log2 | input | L2W | FFT length as log2 (mode 3) |
| wr_data | input | NB*DW | Write vector, lane k at [k*DW +: DW] |
| busy | output | 1 | Transfer in progress |
| rd_valid | output | 1 | rd_data holds a read beat |
| rd_data | output | NB*DW | Read vector, lane k at [k*DW +: DW] |

## Verification
A linear read that starts three words below the top of memory checks lane rotation and address wrap together. A design that does not rotate returns the elements in bank order, and one that does not wrap reads the wrong row. Modulo reads cross the window end in the middle of a beat. A design that wraps only at beat boundaries, or wraps to zero instead of to the base, returns data from outside the window. Data written in FFT natural order is read back bit-reversed at two FFT lengths. Plain low-bit banking would make every lane of a bit-reversed beat hit the same single-port bank, and the beat would come back corrupted. A conflicting start request in the middle of a read supplies all-ones write data. If the design accepted it, a later read would find that data in memory, or the transfer would stop at the wrong cycle.

// File: rtl/vba_pkg.sv
package vba_pkg;
   typedef enum logic [1:0] {
      AM_LINEAR  = 2'd0,
      AM_MODULO  = 2'd1,
      AM_FFT_NAT = 2'd2,
      AM_FFT_REV = 2'd3
   } am_mode_e;
endpackage

// File: rtl/vba_agu.sv
module vba_agu
   import vba_pkg::*;
#(
   parameter int AW = 8,
   parameter int NB = 4,
   localparam int L2W = $clog2(AW + 1)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cfg_go,
   input  logic                     cfg_wr,
   input  logic [1:0]               cfg_mode,
   input  logic [AW-1:0]            cfg_base,
   input  logic [AW-1:0]            cfg_stride,
   input  logic [AW-1:0]            cfg_size,
   input  logic [AW-1:0]            cfg_beats,
   input  logic [L2W-1:0]           cfg_log2,
   output logic                     busy,
   output logic                     is_wr,
   output logic                     fold_en,
   output logic [NB-1:0][AW-1:0]    lane_addr
);
   logic            busy_q, wr_q;
   am_mode_e        mode_q;
   logic [AW-1:0]   base_q, stride_q, size_q, beats_q;
   logic [AW-1:0]   ptr_q, off_q, bcnt_q;
   logic [L2W-1:0]  log2_q;
   logic [AW-1:0]   ptr_step, off_next;
   logic [AW:0]     osum;

   function automatic logic [AW-1:0] rev_n(input logic [AW-1:0] v, input logic [L2W-1:0] n);
      logic [AW-1:0] r;
      for (int i = 0; i < AW; i++) r[i] = v[AW-1-i];
      return r >> (L2W'(AW) - n);
   endfunction

   assign ptr_step = (mode_q == AM_LINEAR) ? stride_q : AW'(NB);

   always_comb begin
      osum = {1'b0, off_q} + {1'b0, ((mode_q == AM_MODULO) ? stride_q : AW'(NB))};
      if (mode_q == AM_MODULO && osum >= {1'b0, size_q}) osum = osum - {1'b0, size_q};
      off_next = osum[AW-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q   <= 1'b0;
         wr_q     <= 1'b0;
         mode_q   <= AM_LINEAR;
         base_q   <= '0;
         stride_q <= '0;
         size_q   <= '0;
         beats_q  <= '0;
         log2_q   <= '0;
         ptr_q    <= '0;
         off_q    <= '0;
         bcnt_q   <= '0;
      end else if (!busy_q) begin
         if (cfg_go && cfg_beats != '0) begin
            busy_q   <= 1'b1;
            wr_q     <= cfg_wr;
            mode_q   <= am_mode_e'(cfg_mode);
            base_q   <= cfg_base;
            stride_q <= cfg_stride;
            size_q   <= cfg_size;
            beats_q  <= cfg_beats;
            log2_q   <= cfg_log2;
            ptr_q    <= cfg_base;
            off_q    <= '0;
            bcnt_q   <= '0;
         end
      end else begin
         bcnt_q <= bcnt_q + 1'b1;
         if (bcnt_q == beats_q - 1'b1) busy_q <= 1'b0;
         ptr_q  <= ptr_q + ptr_step;
         off_q  <= off_next;
      end
   end

   for (genvar k = 0; k < NB; k++) begin : g_lane
      logic [AW:0]   mraw, mwrap;
      assign mraw  = {1'b0, off_q} + (AW+1)'(k);
      assign mwrap = (mraw >= {1'b0, size_q}) ? mraw - {1'b0, size_q} : mraw;
      always_comb begin
         unique case (mode_q)
            AM_MODULO:  lane_addr[k] = base_q + mwrap[AW-1:0];
            AM_FFT_REV: lane_addr[k] = base_q + rev_n(off_q + AW'(k), log2_q);
            default:    lane_addr[k] = ptr_q + AW'(k);
         endcase
      end
   end

   assign busy    = busy_q;
   assign is_wr   = wr_q;
   assign fold_en = (mode_q == AM_FFT_NAT) || (mode_q == AM_FFT_REV);
endmodule

// File: rtl/vba_bank_map.sv
module vba_bank_map #(
   parameter int AW = 8,
   parameter int NB = 4,
   parameter int DW = 16,
   localparam int LB = $clog2(NB),
   localparam int RW = AW - LB,
   localparam int ND = AW / LB
) (
   input  logic                     active,
   input  logic                     wr,
   input  logic                     fold_en,
   input  logic [NB-1:0][AW-1:0]    lane_addr,
   input  logic [NB-1:0][DW-1:0]    lane_wd,
   output logic [NB-1:0]            bank_en,
   output logic [NB-1:0]            bank_we,
   output logic [NB-1:0][RW-1:0]    bank_row,
   output logic [NB-1:0][DW-1:0]    bank_wd,
   output logic [NB-1:0][LB-1:0]    lane_bank
);
   logic [NB-1:0][RW-1:0] lane_row;

   function automatic logic [LB-1:0] fold(input logic [AW-1:0] a);
      logic [LB-1:0] f;
      f = '0;
      for (int d = 0; d < ND; d++) f = f ^ a[d*LB +: LB];
      return f;
   endfunction

   for (genvar k = 0; k < NB; k++) begin : g_sel
      assign lane_bank[k] = fold_en ? fold(lane_addr[k]) : lane_addr[k][LB-1:0];
      assign lane_row[k]  = lane_addr[k][AW-1:LB];
   end

   always_comb begin
      for (int b = 0; b < NB; b++) begin
         bank_en[b]  = 1'b0;
         bank_row[b] = '0;
         bank_wd[b]  = '0;
         for (int k = 0; k < NB; k++) begin
            if (active && lane_bank[k] == LB'(b)) begin
               bank_en[b]  = 1'b1;
               bank_row[b] = bank_row[b] | lane_row[k];
               bank_wd[b]  = bank_wd[b] | lane_wd[k];
            end
         end
         bank_we[b] = bank_en[b] & wr;
      end
   end
endmodule

// File: rtl/vba_bank.sv
module vba_bank #(
   parameter int RW = 6,
   parameter int DW = 16,
   localparam int DEPTH = 1 << RW
) (
   input  logic          clk,
   input  logic          en,
   input  logic          we,
   input  logic [RW-1:0] row,
   input  logic [DW-1:0] wd,
   output logic [DW-1:0] q
);
   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (en) begin
         if (we) mem[row] <= wd;
         else    q        <= mem[row];
      end
   end
endmodule

// File: rtl/vec_bank_agu.sv
module vec_bank_agu #(
   parameter int AW = 8,
   parameter int NB = 4,
   parameter int DW = 16,
   localparam int LB  = $clog2(NB),
   localparam int RW  = AW - LB,
   localparam int L2W = $clog2(AW + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_go,
   input  logic              cfg_wr,
   input  logic [1:0]        cfg_mode,
   input  logic [AW-1:0]     cfg_base,
   input  logic [AW-1:0]     cfg_stride,
   input  logic [AW-1:0]     cfg_size,
   input  logic [AW-1:0]     cfg_beats,
   input  logic [L2W-1:0]    cfg_log2,
   input  logic [NB*DW-1:0]  wr_data,
   output logic              busy,
   output logic              rd_valid,
   output logic [NB*DW-1:0]  rd_data
);
   if (NB < 2 || (1 << LB) != NB) begin : g_bad_nb
      $error("NB must be a power of two of at least 2");
   end
   if (AW <= LB || (AW % LB) != 0) begin : g_bad_aw
      $error("AW must exceed and be a multiple of log2(NB)");
   end
   if (DW < 1) begin : g_bad_dw
      $error("DW must be positive");
   end

   logic                  is_wr, fold_en;
   logic [NB-1:0][AW-1:0] lane_addr;
   logic [NB-1:0][DW-1:0] lane_wd;
   logic [NB-1:0]         bank_en, bank_we;
   logic [NB-1:0][RW-1:0] bank_row;
   logic [NB-1:0][DW-1:0] bank_wd, bank_q;
   logic [NB-1:0][LB-1:0] lane_bank, lane_bank_q;
   logic                  rd_v_q;

   vba_agu #(.AW(AW), .NB(NB)) u_agu (
      .clk(clk), .rst_n(rst_n), .cfg_go(cfg_go), .cfg_wr(cfg_wr),
      .cfg_mode(cfg_mode), .cfg_base(cfg_base), .cfg_stride(cfg_stride),
      .cfg_size(cfg_size), .cfg_beats(cfg_beats), .cfg_log2(cfg_log2),
      .busy(busy), .is_wr(is_wr), .fold_en(fold_en), .lane_addr(lane_addr)
   );

   for (genvar k = 0; k < NB; k++) begin : g_wd
      assign lane_wd[k] = wr_data[k*DW +: DW];
   end

   vba_bank_map #(.AW(AW), .NB(NB), .DW(DW)) u_map (
      .active(busy), .wr(is_wr), .fold_en(fold_en), .lane_addr(lane_addr),
      .lane_wd(lane_wd), .bank_en(bank_en), .bank_we(bank_we),
      .bank_row(bank_row), .bank_wd(bank_wd), .lane_bank(lane_bank)
   );

   for (genvar b = 0; b < NB; b++) begin : g_bank
      vba_bank #(.RW(RW), .DW(DW)) u_bank (
         .clk(clk), .en(bank_en[b]), .we(bank_we[b]), .row(bank_row[b]),
         .wd(bank_wd[b]), .q(bank_q[b])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_v_q      <= 1'b0;
         lane_bank_q <= '0;
      end else begin
         rd_v_q      <= busy & ~is_wr;
         lane_bank_q <= lane_bank;
      end
   end

   for (genvar k = 0; k < NB; k++) begin : g_rd
      assign rd_data[k*DW +: DW] = bank_q[lane_bank_q[k]];
   end

   assign rd_valid = rd_v_q;
endmodule

// File: rtl/vba_chk.sv
module vba_chk #(
   parameter int AW = 8,
   parameter int NB = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cfg_go,
   input logic [AW-1:0] cfg_beats,
   input logic          busy,
   input logic          is_wr,
   input logic          rd_valid,
   input logic [NB-1:0] bank_en
);
   assert_banks_distinct_R8: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> $countones(bank_en) == NB);

   assert_banks_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> bank_en == '0);

   assert_read_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $past(busy) && !$past(is_wr));

   assert_cfg_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(is_wr));

   assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && cfg_go && cfg_beats != '0) |=> busy);

   assert_zero_beats_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && cfg_go && cfg_beats == '0) |=> !busy);
endmodule

bind vec_bank_agu vba_chk #(.AW(AW), .NB(NB)) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_go(cfg_go), .cfg_beats(cfg_beats),
   .busy(busy), .is_wr(is_wr), .rd_valid(rd_valid), .bank_en(bank_en)
);

// File: tb/vec_bank_agu_tb.sv
`timescale 1ns/1ps
module vec_bank_agu_tb;
   localparam int AW = 8, NB = 4, DW = 16, LB = 2, L2W = 4, ROWS = 64;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cfg_go = 1'b0, cfg_wr = 1'b0;
   logic [1:0]        cfg_mode = '0;
   logic [AW-1:0]     cfg_base = '0, cfg_stride = '0, cfg_size = '0, cfg_beats = '0;
   logic [L2W-1:0]    cfg_log2 = '0;
   logic [NB*DW-1:0]  wr_data = '0;
   logic              busy, rd_valid;
   logic [NB*DW-1:0]  rd_data;

   logic [DW-1:0] pm [NB*ROWS];
   int checks = 0, errors = 0;

   vec_bank_agu #(.AW(AW), .NB(NB), .DW(DW)) u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_go(cfg_go), .cfg_wr(cfg_wr),
      .cfg_mode(cfg_mode), .cfg_base(cfg_base), .cfg_stride(cfg_stride),
      .cfg_size(cfg_size), .cfg_beats(cfg_beats), .cfg_log2(cfg_log2),
      .wr_data(wr_data), .busy(busy), .rd_valid(rd_valid), .rd_data(rd_data)
   );

   always #10 clk = ~clk;

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic int brev(input int v, input int n);
      int r = 0;
      for (int i = 0; i < n; i++) if (v[i]) r |= 1 << (n - 1 - i);
      return r;
   endfunction

   function automatic int eaddr(input int mode, input int base, input int stride,
                                input int size, input int l2, input int j, input int k);
      int a;
      case (mode)
         0: a = base + j*stride + k;
         1: a = base + ((j*stride + k) % size);
         2: a = base + j*NB + k;
         default: a = base + brev(j*NB + k, l2);
      endcase
      return a % (1 << AW);
   endfunction

   function automatic int place(input int mode, input int a);
      int bank;
      if (mode >= 2) begin
         bank = 0;
         for (int d = 0; d < AW/LB; d++) bank ^= (a >> (d*LB)) % NB;
      end else bank = a % NB;
      return bank*ROWS + a/NB;
   endfunction

   task automatic chk_beat(input string tag, input int mode, input int base, input int stride,
                           input int size, input int l2, input int j);
      logic [NB*DW-1:0] ev;
      for (int k = 0; k < NB; k++)
         ev[k*DW +: DW] = pm[place(mode, eaddr(mode, base, stride, size, l2, j, k))];
      chk(rd_valid === 1'b1 && rd_data === ev, tag, rd_data, ev);
   endtask

   task automatic run(input string tag, input int mode, input bit wr, input int base,
                      input int stride, input int size, input int beats, input int l2,
                      input int seed, input int inj);
      int bsy_bad = 0;
      @(negedge clk);
      cfg_mode = 2'(mode); cfg_wr = wr; cfg_base = AW'(base); cfg_stride = AW'(stride);
      cfg_size = AW'(size); cfg_beats = AW'(beats); cfg_log2 = L2W'(l2); cfg_go = 1'b1;
      @(negedge clk);
      cfg_go = 1'b0;
      for (int j = 0; j < beats; j++) begin
         if (busy !== 1'b1) bsy_bad++;
         if (j == inj) begin
            cfg_go = 1'b1; cfg_wr = ~wr; cfg_base = '0; cfg_beats = AW'(2); cfg_mode = 2'd0;
         end else cfg_go = 1'b0;
         if (wr) begin
            for (int k = 0; k < NB; k++) begin
               logic [DW-1:0] d;
               d = DW'(seed*256 + j*NB + k);
               wr_data[k*DW +: DW] = d;
               pm[place(mode, eaddr(mode, base, stride, size, l2, j, k))] = d;
            end
         end else begin
            wr_data = '1;
            if (j > 0) chk_beat(tag, mode, base, stride, size, l2, j - 1);
         end
         @(negedge clk);
      end
      cfg_go = 1'b0;
      chk(busy === 1'b0 && bsy_bad == 0, {tag, " R2 busy length"}, {63'd0, busy}, 64'd0);
      if (!wr) chk_beat(tag, mode, base, stride, size, l2, beats - 1);
   endtask

   task automatic t_reset;
      chk(busy === 1'b0, "R1 busy after reset", {63'd0, busy}, 64'd0);
      chk(rd_valid === 1'b0, "R1 rd_valid after reset", {63'd0, rd_valid}, 64'd0);
   endtask

   task automatic t_linear;
      run("R4 fill", 0, 1'b1, 0, 4, 0, 64, 0, 1, -1);
      run("R4 R9 aligned read", 0, 1'b0, 8, 4, 0, 4, 0, 0, -1);
      run("R4 unaligned wrap read", 0, 1'b0, 253, 3, 0, 5, 0, 0, -1);
   endtask

   task automatic t_modulo;
      run("R5 modulo read", 1, 1'b0, 32, 5, 12, 8, 0, 0, -1);
      run("R5 modulo write", 1, 1'b1, 96, 7, 20, 6, 0, 2, -1);
      run("R5 check by linear read", 0, 1'b0, 96, 4, 0, 5, 0, 0, -1);
   endtask

   task automatic t_fft;
      run("R6 natural write", 2, 1'b1, 128, 0, 0, 8, 5, 3, -1);
      run("R6 natural read", 2, 1'b0, 128, 0, 0, 8, 5, 0, -1);
      run("R7 R8 bitrev read L5", 3, 1'b0, 128, 0, 0, 8, 5, 0, -1);
      run("R6 natural write L2", 2, 1'b1, 160, 0, 0, 1, 2, 4, -1);
      run("R7 R8 bitrev read L2", 3, 1'b0, 160, 0, 0, 1, 2, 0, -1);
      run("R10 linear view of folded rows", 0, 1'b0, 128, 4, 0, 8, 0, 0, -1);
   endtask

   task automatic t_ignore;
      run("R3 go while busy", 0, 1'b0, 40, 4, 0, 6, 0, 0, 2);
      run("R3 no stray write", 0, 1'b0, 0, 4, 0, 2, 0, 0, -1);
   endtask

   task automatic t_zero;
      @(negedge clk);
      cfg_beats = '0; cfg_wr = 1'b1; cfg_go = 1'b1;
      @(negedge clk);
      cfg_go = 1'b0;
      chk(busy === 1'b0, "R2 zero beats", {63'd0, busy}, 64'd0);
      @(negedge clk);
      chk(busy === 1'b0, "R2 zero beats later", {63'd0, busy}, 64'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_linear();
      t_modulo();
      t_fft();
      t_ignore();
      t_zero();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule